// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block works out the column addresses of one read or write burst in a double-data-rate SDRAM model or controller. A mode-register write sets two things: the burst length, given as a 3-bit code, and the wrap ordering, either sequential or interleaved. A start strobe with a start column then launches a burst. The block gives two column addresses per clock cycle, one for the rising half of the cycle and one for the falling half. It raises a flag on the final cycle of the burst.

The burst stays inside an aligned block of 2, 4 or 8 columns. Only the low one, two or three column bits change. The upper column bits keep the value of the start column. The settings are taken when the burst starts, so a mode write during a burst does not change that burst. If a start strobe arrives while a burst is running, the running burst is dropped and the new burst begins.

Top module: `burst_col_seq`

## Requirements
- R1: Length code decode on a mode write: 3'b001 gives 2 beats, 3'b010 gives 4 beats, 3'b011 gives 8 beats. After reset the setting is 2 beats, sequential. A write changes only bursts started on a later cycle.
- R2: A mode write with a reserved length code (3'b000, 3'b1xx) sets mode_err on the next cycle and keeps the previous length and ordering. A write with a valid code clears mode_err on the next cycle.
- R3: mode_ilv selects the ordering: 0 is sequential and 1 is interleaved. Both orderings work for all three lengths.
- R4: In sequential ordering, beat k has low bits (s + k) mod BL, where s is the start column's low bits. No carry passes into the upper column bits, which keep the start column's value.
- R5: In interleaved ordering, beat k has low bits s XOR k. The upper column bits keep the start column's value.
- R6: Beats appear two per cycle, starting the cycle after the start strobe. beat_col[COL_W-1:0] carries the even beat 2c and beat_col[2*COL_W-1:COL_W] carries the odd beat 2c+1. A burst lasts BL/2 cycles with burst_active high.
- R7: burst_last is high only in the final cycle of a burst. If no new start arrives, burst_active is low on the cycle after that.
- R8: A start strobe during a burst ends that burst. The next cycle carries beats 0 and 1 of the new burst.
- R9: A mode write during a burst leaves the length and ordering of that burst unchanged.
- R10: While reset is low and just after it, burst_active, burst_last and mode_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_len_code | input | 3 | Burst-length code |
| mode_ilv | input | 1 | Ordering bit, 1 = interleaved |
| mode_err | output | 1 | Last mode write carried a reserved length code |
| start | input | 1 | Burst start strobe |
| start_col | input | COL_W | Start column of the burst |
| burst_active | output | 1 | Beats on beat_col are valid |
| burst_last | output | 1 | Final cycle of the burst |
| beat_col | output | LANES*COL_W | Column per beat, lane 0 in the low bits |

## Verification
The assertions assume that start, mode_wr and their data are driven cleanly between clock edges and are held low while reset is applied. They also assume that the inputs are never unknown once reset is released. The bench drives every input on the falling edge and samples on the falling edge as well. Random stimulus uses all eight length codes, both orderings and any start column, so reserved writes, mode writes during a burst and bursts started at the top of the column range all occur inside these limits.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
   localparam int MAX_LG = 3;        // log2 of the longest burst
   localparam int IDX_W  = MAX_LG;   // width of a beat index
   localparam int CODE_W = 3;

   typedef struct packed {
      logic       ilv;
      logic [1:0] lg;                // log2 of the burst length
   } bmode_t;

   localparam bmode_t MODE_RESET = '{ilv: 1'b0, lg: 2'd1};

   function automatic logic len_code_ok(input logic [CODE_W-1:0] c);
      return (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
   endfunction

   function automatic logic [1:0] len_code_lg(input logic [CODE_W-1:0] c);
      return c[1:0];
   endfunction

   function automatic logic [IDX_W-1:0] lg_mask(input logic [1:0] lg);
      return IDX_W'((4'd1 << lg) - 4'd1);
   endfunction
endpackage

// File: rtl/burst_col_seq_mode.sv
module burst_col_seq_mode
   import burst_col_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CODE_W-1:0] len_code,
   input  logic              ilv,
   output bmode_t            mode,
   output logic              err
);
   bmode_t mode_q;
   logic   err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         err_q  <= 1'b0;
      end else if (wr) begin
         if (len_code_ok(len_code)) begin
            mode_q.lg  <= len_code_lg(len_code);
            mode_q.ilv <= ilv;
            err_q      <= 1'b0;
         end else begin
            err_q      <= 1'b1;
         end
      end
   end

   assign mode = mode_q;
   assign err  = err_q;
endmodule

// File: rtl/burst_col_seq_ctr.sv
module burst_col_seq_ctr
   import burst_col_seq_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  bmode_t           cur_mode,
   output logic             active,
   output logic             last,
   output logic [COL_W-1:0] base_col,
   output bmode_t           run_mode,
   output logic [IDX_W-1:0] cyc
);
   localparam int LANE_LG = $clog2(LANES);

   logic             active_q;
   logic [IDX_W-1:0] cyc_q;
   logic [COL_W-1:0] base_q;
   bmode_t           mode_q;
   logic [IDX_W-1:0] final_cyc;

   assign final_cyc = IDX_W'(((4'd1 << mode_q.lg) >> LANE_LG) - 4'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cyc_q    <= '0;
         base_q   <= '0;
         mode_q   <= MODE_RESET;
      end else if (start) begin
         active_q <= 1'b1;
         cyc_q    <= '0;
         base_q   <= start_col;
         mode_q   <= cur_mode;
      end else if (active_q) begin
         if (cyc_q == final_cyc) begin
            active_q <= 1'b0;
            cyc_q    <= '0;
         end else begin
            cyc_q    <= cyc_q + 1'b1;
         end
      end
   end

   assign active   = active_q;
   assign last     = active_q && (cyc_q == final_cyc);
   assign base_col = base_q;
   assign run_mode = mode_q;
   assign cyc      = cyc_q;
endmodule

// File: rtl/burst_col_seq_lane.sv
module burst_col_seq_lane
   import burst_col_seq_pkg::*;
#(
   parameter int COL_W    = 10,
   parameter int LANES    = 2,
   parameter int LANE_IDX = 0
) (
   input  logic [COL_W-1:0] base_col,
   input  bmode_t           mode,
   input  logic [IDX_W-1:0] cyc,
   output logic [COL_W-1:0] col
);
   localparam int LANE_LG = $clog2(LANES);

   logic [IDX_W-1:0] k;
   logic [IDX_W-1:0] s;
   logic [IDX_W-1:0] mask;
   logic [IDX_W-1:0] seq_low;
   logic [IDX_W-1:0] ilv_low;
   logic [IDX_W-1:0] low;

   assign k       = IDX_W'((cyc << LANE_LG) | IDX_W'(LANE_IDX));
   assign s       = base_col[IDX_W-1:0];
   assign mask    = lg_mask(mode.lg);
   assign seq_low = ((s + k) & mask) | (s & ~mask);
   assign ilv_low = s ^ k;
   assign low     = mode.ilv ? ilv_low : seq_low;

   generate
      if (COL_W > IDX_W) begin : g_upper
         assign col = {base_col[COL_W-1:IDX_W], low};
      end else begin : g_bare
         assign col = low;
      end
   endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_col_seq_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode_wr,
   input  logic [2:0]             mode_len_code,
   input  logic                   mode_ilv,
   output logic                   mode_err,
   input  logic                   start,
   input  logic [COL_W-1:0]       start_col,
   output logic                   burst_active,
   output logic                   burst_last,
   output logic [LANES*COL_W-1:0] beat_col
);
   generate
      if (COL_W < MAX_LG) begin : g_bad_col_w
         $error("burst_col_seq: COL_W must be at least %0d", MAX_LG);
      end
      if (LANES != 1 && LANES != 2) begin : g_bad_lanes
         $error("burst_col_seq: LANES must be 1 or 2");
      end
   endgenerate

   bmode_t           cur_mode;
   bmode_t           run_mode;
   logic [COL_W-1:0] base_col;
   logic [IDX_W-1:0] cyc;

   burst_col_seq_mode u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (mode_wr),
      .len_code (mode_len_code),
      .ilv      (mode_ilv),
      .mode     (cur_mode),
      .err      (mode_err)
   );

   burst_col_seq_ctr #(.COL_W(COL_W), .LANES(LANES)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_col (start_col),
      .cur_mode  (cur_mode),
      .active    (burst_active),
      .last      (burst_last),
      .base_col  (base_col),
      .run_mode  (run_mode),
      .cyc       (cyc)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         burst_col_seq_lane #(.COL_W(COL_W), .LANES(LANES), .LANE_IDX(g)) u_lane (
            .base_col (base_col),
            .mode     (run_mode),
            .cyc      (cyc),
            .col      (beat_col[g*COL_W +: COL_W])
         );
      end
   endgenerate
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
   import burst_col_seq_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int LANES = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   mode_wr,
   input logic [2:0]             mode_len_code,
   input logic                   mode_err,
   input logic                   start,
   input logic                   burst_active,
   input logic                   burst_last,
   input logic [LANES*COL_W-1:0] beat_col
);
   assert_err_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr && !len_code_ok(mode_len_code) |=> mode_err);

   assert_err_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr && len_code_ok(mode_len_code) |=> !mode_err);

   assert_start_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> burst_active);

   assert_last_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_last |-> burst_active);

   assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_last && !start |=> !burst_active);

   assert_upper_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      burst_active && !burst_last && !start |=>
         $stable(beat_col[COL_W-1:0] >> MAX_LG));

   generate
      if (LANES == 2) begin : g_two
         assert_lanes_differ_R6: assert property (@(posedge clk) disable iff (!rst_n)
            burst_active |-> beat_col[COL_W-1:0] != beat_col[2*COL_W-1:COL_W]);
      end
   endgenerate
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .LANES(LANES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_wr       (mode_wr),
   .mode_len_code (mode_len_code),
   .mode_err      (mode_err),
   .start         (start),
   .burst_active  (burst_active),
   .burst_last    (burst_last),
   .beat_col      (beat_col)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
   localparam int COL_W = 10;
   localparam int LANES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_wr = 1'b0;
   logic [2:0] mode_len_code = 3'b000;
   logic mode_ilv = 1'b0;
   logic start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic mode_err;
   logic burst_active;
   logic burst_last;
   logic [LANES*COL_W-1:0] beat_col;

   int  n_tests = 0;
   int  n_fail  = 0;
   int  m_bl    = 2;
   bit  m_ilv   = 1'b0;
   bit  done    = 1'b0;

   always #2 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .LANES(LANES)) uut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_len_code(mode_len_code),
      .mode_ilv(mode_ilv), .mode_err(mode_err), .start(start), .start_col(start_col),
      .burst_active(burst_active), .burst_last(burst_last), .beat_col(beat_col)
   );

   function automatic int exp_col(int s, int k, int bl, bit ilv);
      int m = bl - 1;
      if (ilv) return (s & ~m) | ((s ^ k) & m);
      return (s & ~m) | ((s + k) & m);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_mode(logic [2:0] code, bit ilv);
      bit ok = (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
      mode_wr = 1'b1; mode_len_code = code; mode_ilv = ilv;
      @(negedge clk);
      mode_wr = 1'b0;
      chk("R2 mode_err", int'(mode_err), ok ? 0 : 1);
      if (ok) begin
         m_bl  = 1 << code[1:0];
         m_ilv = ilv;
      end
   endtask

   task automatic check_cycle(string req, int s, int c, int n, int bl, bit ilv);
      chk({req, " active"}, int'(burst_active), 1);
      chk("R7 last", int'(burst_last), (c == n - 1) ? 1 : 0);
      chk({req, " even beat"}, int'(beat_col[COL_W-1:0]), exp_col(s, 2*c, bl, ilv));
      chk({req, " odd beat"}, int'(beat_col[2*COL_W-1:COL_W]), exp_col(s, 2*c+1, bl, ilv));
   endtask

   task automatic run_burst(int s);
      int n = m_bl / LANES;
      string req = m_ilv ? "R5" : "R4";
      start = 1'b1; start_col = COL_W'(s);
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < n; c++) begin
         check_cycle(req, s, c, n, m_bl, m_ilv);
         @(negedge clk);
      end
      chk("R7 idle after last", int'(burst_active), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 active", int'(burst_active), 0);
      chk("R10 last", int'(burst_last), 0);
      chk("R10 err", int'(mode_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 active after release", int'(burst_active), 0);

      // R1: default 2-beat sequential
      run_burst(13);
      // R1 R4: 4-beat sequential from low bits 2
      write_mode(3'b010, 1'b0);
      run_burst(6);
      // R3 R5: 8-beat interleaved
      write_mode(3'b011, 1'b1);
      run_burst(10'h1F5);
      // R2: reserved code keeps setting
      write_mode(3'b111, 1'b0);
      run_burst(10'h1F5);
      write_mode(3'b000, 1'b0);
      run_burst(3);
      // R4: no carry at top of range
      write_mode(3'b011, 1'b0);
      chk("R2 cleared", int'(mode_err), 0);
      run_burst(1023);
      write_mode(3'b010, 1'b1);
      run_burst(1021);

      // R8: restart during burst
      write_mode(3'b011, 1'b0);
      start = 1'b1; start_col = 10'd0;
      @(negedge clk);
      start = 1'b0;
      check_cycle("R8", 0, 0, 4, 8, 1'b0);
      run_burst(100);

      // R9: mode write during a burst
      start = 1'b1; start_col = 10'd40;
      @(negedge clk);
      start = 1'b0;
      mode_wr = 1'b1; mode_len_code = 3'b001; mode_ilv = 1'b1;
      check_cycle("R9", 40, 0, 4, 8, 1'b0);
      @(negedge clk);
      mode_wr = 1'b0;
      for (int c = 1; c < 4; c++) begin
         check_cycle("R9", 40, c, 4, 8, 1'b0);
         @(negedge clk);
      end
      chk("R9 end", int'(burst_active), 0);
      m_bl = 2; m_ilv = 1'b1;
      run_burst(41);   // R1: new setting applies to the later burst

      // random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 80; i++) begin
         if ($urandom_range(0, 2) == 0)
            write_mode(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
         run_burst(int'($urandom_range(0, 1023)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule